// File: doc/BRIEF.md
# Scrambled Packet Framer

This block turns one packet into a serial bitstream, one bit per clock. A packet has four sections in a fixed order: a preamble, an address, a payload and an optional check sequence. The address and the payload can be whitened by a short linear feedback shift register. The preamble and the check sequence are never whitened. The check sequence is computed over the clear address and payload bits, before any whitening.

A packet begins with a one-cycle `start_i` while the block is idle. In that cycle the block captures the address width code, the address value, the payload length and the two enables. Payload bytes then arrive through a valid/ready handshake, one byte per accepted transfer. Each section is sent one byte at a time, most significant bit first. `bit_valid_o` marks every cycle that carries a real bit. `eop_o` marks the last bit of the packet.

Top module: `pkt_framer`

## Requirements
- R1: While `rst_ni` is low and after reset, `bit_valid_o`, `eop_o`, `busy_o` and `pay_ready_o` are 0.
- R2: A packet is sent as preamble, address, payload and then the check sequence if it is enabled. Every byte goes out MSB first. Address bytes go out starting with `addr_i[7:0]` and working upward.
- R3: The preamble is 3 bytes. Each preamble byte is 0xAA when bit 7 of address byte 0 is 1, and 0x55 otherwise.
- R4: `aw_i` selects the address length: 0 gives 3 bytes, 1 gives 4 bytes, and both 2 and 3 give 5 bytes.
- R5: The payload length is `pay_len_i`+1 bytes, so the range is 1 to 32.
- R6: When `crc_en_i` is 1, the packet ends with 16 check bits. They use polynomial 0x1021 and seed 0xFFFF. The register shifts MSB first over the clear address and payload bits. Bit 15 is sent first, and these bits are never whitened. When `crc_en_i` is 0, the packet ends after the payload.
- R7: When `scr_en_i` is 1, each address and payload bit is XORed with bit 6 of a 7-bit register. The register is seeded with 0x7F at packet start. After each such bit it shifts to {r[5:0], r[6]^r[3]}. The preamble and check bits are never whitened.
- R8: `pay_ready_o` is 1 only at a byte boundary inside the payload section. If `pay_valid_i` is 0 in such a cycle, no bit is emitted in the next cycle. Exactly the payload length in bytes is accepted per packet.
- R9: `eop_o` is 1 together with the final bit of the packet and at no other time. `busy_o` is already 0 in that cycle.
- R10: `start_i` takes effect only when `busy_o` is 0, and `busy_o` rises in the next cycle. Changes to `start_i` or to the configuration inputs during a packet do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a packet (taken when idle) |
| aw_i | input | 2 | Address length code |
| addr_i | input | 40 | Address value, byte 0 in bits 7:0 |
| pay_len_i | input | 5 | Payload length minus one |
| crc_en_i | input | 1 | Append check sequence |
| scr_en_i | input | 1 | Whiten address and payload |
| pay_data_i | input | 8 | Payload byte |
| pay_valid_i | input | 1 | Payload byte offered |
| pay_ready_o | output | 1 | Payload byte wanted this cycle |
| busy_o | output | 1 | Packet in progress |
| bit_o | output | 1 | Serial data bit |
| bit_valid_o | output | 1 | `bit_o` carries a packet bit |
| eop_o | output | 1 | Last bit of the packet |

## Verification
Several things can happen in the same cycle. A payload byte is accepted, its first bit is emitted straight from `pay_data_i`, that bit steps both the whitening register and the check register, and it may also be the final bit of the payload section. The bench sweeps every address code, both enables and payload lengths of 1, 3 and 32. It alternates between an unbroken byte supply and one where `pay_valid_i` drops at random byte boundaries, while the configuration inputs and `start_i` change during each packet. For each packet, the bits collected on `bit_valid_o` are compared with a stream the bench computes from the requirements. The bench also checks the `eop_o` position, the accepted byte count and that nothing is emitted after a stalled boundary.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
  typedef enum logic [2:0] {
    SEC_IDLE,
    SEC_PRE,
    SEC_ADDR,
    SEC_PAY,
    SEC_CRC
  } sec_e;
endpackage

// File: rtl/pkt_framer_whiten.sv
module pkt_framer_whiten #(
  parameter logic [6:0] SEED = 7'h7F
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  output logic key_o
);
  logic [6:0] lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lfsr_q <= SEED;
    else if (load_i)  lfsr_q <= SEED;
    else if (step_i)  lfsr_q <= {lfsr_q[5:0], lfsr_q[6] ^ lfsr_q[3]};
  end

  assign key_o = lfsr_q[6];
endmodule

// File: rtl/pkt_framer_crc.sv
module pkt_framer_crc #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        step_i,
  input  logic        din_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;
  logic        fb;

  assign fb = crc_q[15] ^ din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= INIT;
    else if (init_i)  crc_q <= INIT;
    else if (step_i)  crc_q <= {crc_q[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import pkt_framer_pkg::*;
#(
  parameter int         PRE_BYTES = 3,
  parameter int         ADDR_MIN  = 3,
  parameter int         ADDR_MAX  = 5,
  parameter int         PAY_MAX   = 32,
  parameter logic [6:0] SCR_SEED  = 7'h7F
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [1:0]                  aw_i,
  input  logic [8*ADDR_MAX-1:0]       addr_i,
  input  logic [$clog2(PAY_MAX)-1:0]  pay_len_i,
  input  logic                        crc_en_i,
  input  logic                        scr_en_i,
  input  logic [7:0]                  pay_data_i,
  input  logic                        pay_valid_i,
  output logic                        pay_ready_o,
  output logic                        busy_o,
  output logic                        bit_o,
  output logic                        bit_valid_o,
  output logic                        eop_o
);
  localparam int LW        = $clog2(PAY_MAX);
  localparam int CRC_BYTES = 2;

  sec_e                  sec_q, sec_nxt;
  logic [LW-1:0]         bcnt_q, sec_last, alast_d, alast_q, plast_q;
  logic [2:0]            bidx_q;
  logic [8*ADDR_MAX-1:0] addr_q;
  logic                  crc_en_q, scr_en_q;
  logic [7:0]            pay_q, cur_byte, addr_byte, pre_byte;
  logic [15:0]           crc_val;
  logic                  take_start, emit, in_body, raw_bit, key, out_bit;
  logic                  byte_end, sec_end, last_bit;
  logic                  bit_q, vld_q, eop_q;

  assign take_start = start_i && (sec_q == SEC_IDLE);
  assign in_body    = (sec_q == SEC_ADDR) || (sec_q == SEC_PAY);
  assign pay_ready_o = (sec_q == SEC_PAY) && (bidx_q == 3'd0);
  assign emit       = (sec_q != SEC_IDLE) && !(pay_ready_o && !pay_valid_i);

  // address length code, upper codes clamp to the maximum
  always_comb begin
    alast_d = LW'(ADDR_MAX - 1);
    if (ADDR_MIN - 1 + int'(aw_i) < ADDR_MAX - 1) alast_d = LW'(ADDR_MIN - 1 + int'(aw_i));
  end

  always_comb begin
    addr_byte = addr_q[7:0];
    for (int i = 0; i < ADDR_MAX; i++)
      if (bcnt_q == LW'(i)) addr_byte = addr_q[8*i +: 8];
  end

  assign pre_byte = addr_q[7] ? 8'hAA : 8'h55;

  always_comb begin
    cur_byte = 8'h00;
    sec_last = '0;
    sec_nxt  = sec_q;
    unique case (sec_q)
      SEC_PRE:  begin cur_byte = pre_byte;  sec_last = LW'(PRE_BYTES - 1); sec_nxt = SEC_ADDR; end
      SEC_ADDR: begin cur_byte = addr_byte; sec_last = alast_q;            sec_nxt = SEC_PAY;  end
      SEC_PAY:  begin
        cur_byte = (bidx_q == 3'd0) ? pay_data_i : pay_q;
        sec_last = plast_q;
        sec_nxt  = crc_en_q ? SEC_CRC : SEC_IDLE;
      end
      SEC_CRC:  begin
        cur_byte = bcnt_q[0] ? crc_val[7:0] : crc_val[15:8];
        sec_last = LW'(CRC_BYTES - 1);
        sec_nxt  = SEC_IDLE;
      end
      default: ;
    endcase
  end

  assign raw_bit  = cur_byte[3'd7 - bidx_q];
  assign out_bit  = raw_bit ^ (in_body && scr_en_q && key);
  assign byte_end = emit && (bidx_q == 3'd7);
  assign sec_end  = byte_end && (bcnt_q == sec_last);
  assign last_bit = sec_end && (sec_nxt == SEC_IDLE);

  pkt_framer_whiten #(.SEED(SCR_SEED)) i_whiten (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (take_start),
    .step_i (emit && in_body),
    .key_o  (key)
  );

  pkt_framer_crc i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (take_start),
    .step_i (emit && in_body),
    .din_i  (raw_bit),
    .crc_o  (crc_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q    <= SEC_IDLE;
      bcnt_q   <= '0;
      bidx_q   <= '0;
      addr_q   <= '0;
      alast_q  <= '0;
      plast_q  <= '0;
      crc_en_q <= 1'b0;
      scr_en_q <= 1'b0;
      pay_q    <= '0;
    end else if (take_start) begin
      sec_q    <= SEC_PRE;
      bcnt_q   <= '0;
      bidx_q   <= '0;
      addr_q   <= addr_i;
      alast_q  <= alast_d;
      plast_q  <= pay_len_i;
      crc_en_q <= crc_en_i;
      scr_en_q <= scr_en_i;
    end else if (emit) begin
      if (pay_ready_o) pay_q <= pay_data_i;
      bidx_q <= bidx_q + 3'd1;
      if (sec_end) begin
        sec_q  <= sec_nxt;
        bcnt_q <= '0;
      end else if (byte_end) begin
        bcnt_q <= bcnt_q + LW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
      eop_q <= 1'b0;
    end else begin
      bit_q <= emit && out_bit;
      vld_q <= emit;
      eop_q <= last_bit;
    end
  end

  assign busy_o      = (sec_q != SEC_IDLE);
  assign bit_o       = bit_q;
  assign bit_valid_o = vld_q;
  assign eop_o       = eop_q;
endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic pay_valid_i,
  input logic pay_ready_o,
  input logic busy_o,
  input logic bit_valid_o,
  input logic eop_o
);
  assert_eop_has_bit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> bit_valid_o);

  assert_eop_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> !busy_o);

  assert_idle_silent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !bit_valid_o);

  assert_ready_in_pkt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_ready_o |-> busy_o);

  assert_stall_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_ready_o && !pay_valid_i) |=> !bit_valid_o);

  assert_start_taken_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
endmodule

bind pkt_framer pkt_framer_chk i_pkt_framer_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .pay_valid_i (pay_valid_i),
  .pay_ready_o (pay_ready_o),
  .busy_o      (busy_o),
  .bit_valid_o (bit_valid_o),
  .eop_o       (eop_o)
);

// File: tb/test_pkt_framer.sv
`timescale 1ns/1ps
module test_pkt_framer;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [1:0]  aw_i;
  logic [39:0] addr_i;
  logic [4:0]  pay_len_i;
  logic        crc_en_i, scr_en_i;
  logic [7:0]  pay_data_i;
  logic        pay_valid_i;
  logic        pay_ready_o, busy_o, bit_o, bit_valid_o, eop_o;

  int checks = 0;
  int failures = 0;

  logic [7:0] pay [32];
  bit exp_b [0:1023];
  bit got_b [0:1023];
  int en, gn;
  int pre_end, addr_end, pay_end;

  always #4 clk_i = ~clk_i;

  pkt_framer i_pkt_framer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .aw_i(aw_i), .addr_i(addr_i),
    .pay_len_i(pay_len_i), .crc_en_i(crc_en_i), .scr_en_i(scr_en_i),
    .pay_data_i(pay_data_i), .pay_valid_i(pay_valid_i), .pay_ready_o(pay_ready_o),
    .busy_o(busy_o), .bit_o(bit_o), .bit_valid_o(bit_valid_o), .eop_o(eop_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string sec_req(input int idx);
    if (idx < pre_end) return "R3";
    if (idx < pay_end) return "R7";
    return "R6";
  endfunction

  task automatic build(input int aw, input logic [39:0] a, input int len, input bit crc, input bit scr);
    int nb;
    logic [6:0] lf;
    logic [15:0] c;
    logic [7:0] by;
    bit r, fb;
    nb = (aw >= 2) ? 5 : 3 + aw;
    en = 0;
    for (int i = 0; i < 3; i++)
      for (int b = 7; b >= 0; b--) begin
        by = a[7] ? 8'hAA : 8'h55;
        exp_b[en++] = by[b];
      end
    pre_end = en;
    lf = 7'h7F;
    c = 16'hFFFF;
    for (int i = 0; i < nb + len; i++) begin
      by = (i < nb) ? a[8*i +: 8] : pay[i - nb];
      for (int b = 7; b >= 0; b--) begin
        r = by[b];
        fb = c[15] ^ r;
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
        exp_b[en++] = r ^ (scr & lf[6]);
        lf = {lf[5:0], lf[6] ^ lf[3]};
      end
      if (i == nb - 1) addr_end = en;
    end
    pay_end = en;
    if (crc)
      for (int b = 15; b >= 0; b--) exp_b[en++] = c[b];
  endtask

  task automatic run_pkt(input int aw, input int len, input bit crc, input bit scr, input bit stall);
    logic [39:0] a;
    int taken, cyc, eop_n, eop_pos, stall_bad, mism;
    bit done, prev_stall, busy_at_eop;
    a = {$urandom, $urandom};
    a[7] = scr ^ aw[0] ^ len[0];
    for (int i = 0; i < 32; i++) pay[i] = 8'($urandom);
    build(aw, a, len, crc, scr);

    @(negedge clk_i);
    aw_i = 2'(aw); addr_i = a; pay_len_i = 5'(len - 1);
    crc_en_i = crc; scr_en_i = scr; start_i = 1'b1; pay_valid_i = 1'b0;
    @(negedge clk_i);
    check(busy_o == 1'b1, "R10", "busy after start", int'(busy_o), 1);

    gn = 0; taken = 0; cyc = 0; eop_n = 0; eop_pos = -1; stall_bad = 0;
    done = 0; busy_at_eop = 1'b1;
    while (!done && cyc < 4000) begin
      // configuration churn while busy: must have no effect (R10)
      start_i = 1'($urandom); aw_i = 2'($urandom); addr_i = {$urandom, $urandom};
      pay_len_i = 5'($urandom); crc_en_i = 1'($urandom); scr_en_i = 1'($urandom);
      pay_valid_i = stall ? (($urandom % 3) != 0) : 1'b1;
      pay_data_i = (taken < len) ? pay[taken] : 8'hEE;
      #1;
      if (pay_ready_o && pay_valid_i) taken++;
      prev_stall = pay_ready_o && !pay_valid_i;
      @(negedge clk_i);
      cyc++;
      if (prev_stall && bit_valid_o) stall_bad++;
      if (bit_valid_o) got_b[gn++] = bit_o;
      if (eop_o) begin
        eop_n++;
        eop_pos = gn;
        busy_at_eop = busy_o;
        done = 1;
      end
      if (!bit_valid_o && eop_o) eop_n += 100;
    end
    start_i = 1'b0;
    pay_valid_i = 1'b0;

    check(gn == en, "R4", "bit count (R2 R5 R6)", gn, en);
    mism = -1;
    for (int i = 0; i < en && i < gn; i++)
      if (mism < 0 && got_b[i] != exp_b[i]) mism = i;
    if (mism >= 0) check(1'b0, sec_req(mism), "bit mismatch at index (R2)", mism, -1);
    else check(1'b1, "R2", "stream", 0, 0);
    check(eop_n == 1 && eop_pos == en, "R9", "eop position", eop_pos, en);
    check(busy_at_eop == 1'b0, "R9", "busy at eop", int'(busy_at_eop), 0);
    check(taken == len, "R8", "bytes accepted (R5)", taken, len);
    check(stall_bad == 0, "R8", "bits after stalled boundary", stall_bad, 0);
    @(negedge clk_i);
    check(busy_o == 1'b0 && bit_valid_o == 1'b0, "R10", "idle after packet", int'(busy_o), 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog R9 actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lens [3];
    int k;
    lens[0] = 1; lens[1] = 3; lens[2] = 32;
    rst_ni = 1'b0; start_i = 1'b0; aw_i = '0; addr_i = '0; pay_len_i = '0;
    crc_en_i = 1'b0; scr_en_i = 1'b0; pay_data_i = '0; pay_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(!bit_valid_o && !eop_o && !busy_o && !pay_ready_o, "R1", "outputs in reset",
          int'({bit_valid_o, eop_o, busy_o, pay_ready_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!bit_valid_o && !busy_o && !pay_ready_o, "R1", "outputs after reset",
          int'({bit_valid_o, busy_o, pay_ready_o}), 0);
    k = 0;
    for (int aw = 0; aw < 4; aw++)
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 2; s++)
          for (int li = 0; li < 3; li++) begin
            run_pkt(aw, lens[li], c[0], s[0], k[0]);
            k++;
          end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule